// File: doc/BRIEF.md
# Two-State Bursty Cell Source

This block generates synthetic cell traffic for one input of a switch. It behaves as an on/off source with two states: while active it emits exactly one cell in every slot, while idle it emits nothing. At each slot the source uses a pseudo-random sample to decide whether to change state. It compares the sample with a threshold that belongs to the current state. One threshold sets the chance of waking from idle and the other the chance of stopping a burst. Together they fix the offered load and the mean burst length. Software or a test harness works these thresholds out ahead of time.

A burst is the unbroken run of cells produced by consecutive active slots. Every cell of a burst carries the same destination port. The destination is drawn afresh from the random sample in the slot where the source decides to wake. Each cell is also marked as the first cell of its burst, the last cell, or both. A downstream scheduler can therefore treat whole bursts as units without counting cells.

Top module: `onoff_cell_source`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs `cell_vld_o`, `burst_sob_o`, `burst_eob_o` and `cell_dest_o` become 0, the state becomes idle, and the generator register loads `seed_i`, or 16'hACE1 when `seed_i` is zero.
- R2: The generator is a 16-bit Fibonacci shift register: next = {g[14:0], g[15]^g[13]^g[12]^g[10]}. It advances exactly once on each clock edge with `slot_i` high and holds otherwise. The sample for a slot is the register value before that advance.
- R3: At a slot, an idle source turns active when sample < `wake_thr_i`. An active source turns idle when sample < `quit_thr_i`. Both comparisons are unsigned.
- R4: At each slot edge, `cell_vld_o` becomes 1 if the state before the edge was active and 0 if it was idle.
- R5: All outputs change only on clock edges where `slot_i` is high and hold their value between slots.
- R6: `burst_sob_o` is 1 for a slot exactly when that slot emits a cell and the previous slot emitted none (or no slot has happened since reset).
- R7: `burst_eob_o` is 1 for a slot exactly when that slot emits a cell and the same slot decides to turn idle (R3). A single-cell burst raises both `burst_sob_o` and `burst_eob_o`.
- R8: `cell_dest_o` loads sample[PORT_W-1:0] at the slot where an idle source decides to wake, and is unchanged at every other slot. As a result, all cells of a burst carry one destination.
- R9: A threshold of 0 makes its state absorbing: with `wake_thr_i` = 0 an idle source never emits, and with `quit_thr_i` = 0 a running burst never ends.
- R10: A zero seed is replaced by 16'hACE1, so the generator never sits at the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the seed |
| slot_i | input | 1 | One-cycle strobe marking a cell slot |
| seed_i | input | 16 | Generator seed captured during reset |
| wake_thr_i | input | 16 | Idle-to-active threshold |
| quit_thr_i | input | 16 | Active-to-idle threshold |
| cell_vld_o | output | 1 | A cell is emitted in the current slot |
| cell_dest_o | output | PORT_W | Destination port of the current burst |
| burst_sob_o | output | 1 | Current cell opens a burst |
| burst_eob_o | output | 1 | Current cell closes a burst |

## Verification
The bench builds the block with the default PORT_W of 4, so destinations span 16 ports. Four bits give enough variety that a destination changing inside a burst, or being loaded at the wrong slot, shows up within a few bursts. The sixteen-bit generator width is fixed, and the bench steps its own reference model from the stated polynomial. Thresholds of zero, mid-range values and 16'hFFFF bring absorbing states, long random bursts and one-cell bursts within reach. Uneven gaps between slot strobes expose any output that moves outside a slot.

// File: rtl/onoff_src_pkg.sv
package onoff_src_pkg;
  localparam int GEN_W = 16;
  localparam logic [GEN_W-1:0] SEED_SUBST = 16'hACE1;

  typedef enum logic {ST_IDLE = 1'b0, ST_ACT = 1'b1} src_state_e;

  // One step of the maximal-length shift register
  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] v);
    return {v[GEN_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction
endpackage

// File: rtl/onoff_gen.sv
module onoff_gen
  import onoff_src_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [GEN_W-1:0] seed,
  output logic [GEN_W-1:0] gen_q
);
  always_ff @(posedge clk) begin
    if (rst)      gen_q <= (seed == '0) ? SEED_SUBST : seed;
    else if (adv) gen_q <= gen_step(gen_q);
  end

  // R10: the register never reaches zero
  a_r10_nonzero: assert property (@(posedge clk) disable iff (rst) gen_q != '0);
  // R2: no advance without a slot
  a_r2_hold: assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(gen_q));
endmodule

// File: rtl/onoff_state.sv
module onoff_state
  import onoff_src_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slot,
  input  logic [GEN_W-1:0] sample,
  input  logic [GEN_W-1:0] wake_thr,
  input  logic [GEN_W-1:0] quit_thr,
  output src_state_e       st,
  output logic             flip
);
  always_comb begin
    if (st == ST_ACT) flip = (sample < quit_thr);
    else              flip = (sample < wake_thr);
  end

  always_ff @(posedge clk) begin
    if (rst)                st <= ST_IDLE;
    else if (slot && flip)  st <= (st == ST_ACT) ? ST_IDLE : ST_ACT;
  end

  // R9: zero exit threshold keeps an active source active
  a_r9_stay_active: assert property (@(posedge clk) disable iff (rst)
    (slot && st == ST_ACT && quit_thr == '0) |=> st == ST_ACT);
  // R9: zero wake threshold keeps an idle source idle
  a_r9_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (slot && st == ST_IDLE && wake_thr == '0) |=> st == ST_IDLE);
  // R3: state moves only on a slot
  a_r3_no_move: assert property (@(posedge clk) disable iff (rst) !slot |=> $stable(st));
endmodule

// File: rtl/onoff_frame.sv
module onoff_frame
  import onoff_src_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot,
  input  src_state_e        st,
  input  logic              flip,
  input  logic [PORT_W-1:0] pick,
  output logic              vld,
  output logic              sob,
  output logic              eob,
  output logic [PORT_W-1:0] dest
);
  logic act;
  assign act = (st == ST_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      sob  <= 1'b0;
      eob  <= 1'b0;
      dest <= '0;
    end else if (slot) begin
      vld <= act;
      sob <= act && !vld;
      eob <= act && flip;
      if (!act && flip) dest <= pick;
    end
  end

  // R1: reset clears the framing outputs
  a_r1_reset: assert property (@(posedge clk) rst |=> (!vld && !sob && !eob && dest == '0));
  // R5: outputs frozen between slots
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !slot |=> ($stable(vld) && $stable(sob) && $stable(eob) && $stable(dest)));
  // R6: a start marker rides on a cell
  a_r6_sob_cell: assert property (@(posedge clk) disable iff (rst) sob |-> vld);
  // R7: an end marker rides on a cell
  a_r7_eob_cell: assert property (@(posedge clk) disable iff (rst) eob |-> vld);
  // R8: destination never moves while cells flow
  a_r8_dest_fixed: assert property (@(posedge clk) disable iff (rst) vld |-> $stable(dest));
endmodule

// File: rtl/onoff_cell_source.sv
module onoff_cell_source
  import onoff_src_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_i,
  input  logic [15:0]       seed_i,
  input  logic [15:0]       wake_thr_i,
  input  logic [15:0]       quit_thr_i,
  output logic              cell_vld_o,
  output logic [PORT_W-1:0] cell_dest_o,
  output logic              burst_sob_o,
  output logic              burst_eob_o
);
  logic [GEN_W-1:0] sample;
  src_state_e       st;
  logic             flip;

  onoff_gen u_gen (
    .clk   (clk),
    .rst   (rst),
    .adv   (slot_i),
    .seed  (seed_i),
    .gen_q (sample)
  );

  onoff_state u_state (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot_i),
    .sample   (sample),
    .wake_thr (wake_thr_i),
    .quit_thr (quit_thr_i),
    .st       (st),
    .flip     (flip)
  );

  onoff_frame #(.PORT_W(PORT_W)) u_frame (
    .clk  (clk),
    .rst  (rst),
    .slot (slot_i),
    .st   (st),
    .flip (flip),
    .pick (sample[PORT_W-1:0]),
    .vld  (cell_vld_o),
    .sob  (burst_sob_o),
    .eob  (burst_eob_o),
    .dest (cell_dest_o)
  );
endmodule

// File: tb/onoff_cell_source_test.sv
module onoff_cell_source_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slot = 1'b0;
  logic [15:0]   seed = 16'h1234;
  logic [15:0]   wake_thr = 16'h0;
  logic [15:0]   quit_thr = 16'h0;
  logic          vld, sob, eob;
  logic [PW-1:0] dest;

  int errors = 0;
  int checks = 0;

  typedef struct {
    bit          vld;
    bit          sob;
    bit          eob;
    bit [PW-1:0] dest;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;

  // reference model, built from the requirements
  bit [15:0]   m_gen;
  bit          m_act;
  bit          m_prev_vld;
  bit [PW-1:0] m_dest;

  always #(CLK_PERIOD/2) clk = ~clk;

  onoff_cell_source #(.PORT_W(PW)) uut (
    .clk         (clk),
    .rst         (rst),
    .slot_i      (slot),
    .seed_i      (seed),
    .wake_thr_i  (wake_thr),
    .quit_thr_i  (quit_thr),
    .cell_vld_o  (vld),
    .cell_dest_o (dest),
    .burst_sob_o (sob),
    .burst_eob_o (eob)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_reset(input bit [15:0] s);
    @(negedge clk);
    seed = s;
    rst  = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_gen      = (s == 16'h0) ? 16'hACE1 : s;  // R10
    m_act      = 1'b0;
    m_prev_vld = 1'b0;
    m_dest     = '0;
    last_exp   = '{vld: 1'b0, sob: 1'b0, eob: 1'b0, dest: '0};
    // R1: reset state at the ports
    check("R1 vld", vld, 0);
    check("R1 sob", sob, 0);
    check("R1 eob", eob, 0);
    check("R1 dest", dest, 0);
  endtask

  function automatic exp_t model_step();
    exp_t e;
    bit [15:0] s;
    bit lv;
    s  = m_gen;                                         // R2: sample before advance
    lv = m_act ? (s < quit_thr) : (s < wake_thr);       // R3
    e.vld = m_act;                                      // R4
    e.sob = m_act && !m_prev_vld;                       // R6
    e.eob = m_act && lv;                                // R7
    if (!m_act && lv) m_dest = s[PW-1:0];               // R8
    e.dest = m_dest;
    m_prev_vld = m_act;
    if (lv) m_act = !m_act;
    m_gen = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};   // R2 polynomial
    return e;
  endfunction

  // driver: pushes the expected item and pulses one slot, then idles
  task automatic run_slots(input int n, input int maxgap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      last_exp = model_step();
      exp_q.push_back(last_exp);
      slot = 1'b1;
      @(negedge clk);
      slot = 1'b0;
      for (int g = 0; g < $urandom_range(maxgap, 0); g++) begin
        @(negedge clk);
        // R5: outputs hold between slots
        check("R5 hold vld", vld, last_exp.vld);
        check("R5 hold dest", dest, last_exp.dest);
      end
    end
  endtask

  // monitor: pops and compares after each slot edge
  always @(posedge clk) begin
    if (slot && !rst) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: actual=output expected=no pending item");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R4 cell_vld", vld, e.vld);
        check("R6 sob", sob, e.sob);
        check("R7 eob", eob, e.eob);
        check("R8 dest", dest, e.dest);
      end
    end
  end

  int sob_cnt;
  int eob_cnt;
  always @(negedge clk) begin
    if (slot === 1'b0 && !rst) begin end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // mixed random bursts (R2, R3, R4, R6, R7, R8)
    do_reset(16'h1234);
    wake_thr = 16'h4000;
    quit_thr = 16'h2000;
    run_slots(300, 3);

    // R9: zero wake threshold, never emits
    do_reset(16'hBEEF);
    wake_thr = 16'h0;
    quit_thr = 16'h8000;
    run_slots(60, 2);
    check("R9 idle absorbing", vld, 0);

    // R9: wake at once, then a burst that never ends
    wake_thr = 16'hFFFF;
    quit_thr = 16'h0;
    run_slots(80, 1);
    check("R9 active absorbing", vld, 1);
    check("R9 no end marker", eob, 0);

    // R10: zero seed substitution, short alternating bursts (R6 and R7 together)
    do_reset(16'h0000);
    wake_thr = 16'hFFFF;
    quit_thr = 16'hFFFF;
    run_slots(120, 2);

    // long bursts with sparse wakes
    do_reset(16'h5A5A);
    wake_thr = 16'h1000;
    quit_thr = 16'h0800;
    run_slots(250, 0);

    repeat (3) @(negedge clk);
    check("R4 queue drained", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule